// File: doc/BRIEF.md
# Paged DMA Address Generator

This block produces the 24-bit physical memory address for one DMA channel. The address is built from an 8-bit page value and a 16-bit current offset. It also keeps the transfer count for the channel. A host loads a page, a base offset and a base count, and selects the transfer width (byte or word) and the direction. After that, each transfer strobe moves the offset by one and lowers the count by one.

In byte mode the page selects one of 256 windows of 64 KB. In word mode the page selects one of 128 windows of 128 KB, and the offset counts 16-bit words. The offset wraps inside its 16 bits and never carries into the page, so a run of transfers stays inside one window. When the count goes from zero to all ones, the block gives a one-cycle terminal-count pulse. If auto-initialise is set, the offset and the count also return to their base values at that point. The block reports the remaining transfer count and the same residue expressed in bytes.

Top module: `dma_page_addr_gen`

## Requirements
- R1: When `word_mode`=0, `phys_addr[23:16]` equals the stored page and `phys_addr[15:0]` equals the current offset.
- R2: When `word_mode`=1, `phys_addr[23:17]` equals stored page bits 7:1, `phys_addr[16:1]` equals the current offset, and `phys_addr[0]` is 0.
- R3: A page loaded while `word_mode`=1 is stored with bit 0 cleared. The cleared bit stays visible in `phys_addr[16]` after the block returns to byte mode.
- R4: Transfers never change the stored page. An incrementing strobe at offset 0xFFFF gives offset 0x0000, and a decrementing strobe at 0x0000 gives 0xFFFF, with the page unchanged.
- R5: Each strobe (`xfer`=1, `load`=0) changes the offset by +1 when `dec_mode`=0 and by -1 when `dec_mode`=1. The new value is visible after the next clock edge.
- R6: `load` stores the count, which holds the length minus one. Each strobe lowers `remaining` by one.
- R7: A strobe taken while `remaining`=0 sets `remaining` to 0xFFFF (when auto-initialise is off) and raises `tc` for exactly the one cycle after that edge. At all other times `tc` is 0.
- R8: When `auto_init`=1, the terminal strobe reloads the offset and the count from their base values instead of stepping or wrapping.
- R9: `residue_bytes` equals `remaining`+1 in byte mode and 2*(`remaining`+1) in word mode.
- R10: When `load` and `xfer` are both high, the load wins. The loaded values appear unmodified and `tc` stays 0.
- R11: After reset the page, offset and count are 0 and `tc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Load page, base offset and base count |
| page_in | input | 8 | Page value to load |
| base_ofs_in | input | 16 | Base offset to load |
| base_cnt_in | input | 16 | Base count (length minus one) to load |
| word_mode | input | 1 | 0 = byte transfers, 1 = word transfers |
| dec_mode | input | 1 | 0 = offset increments, 1 = offset decrements |
| auto_init | input | 1 | Reload from base values at terminal count |
| xfer | input | 1 | One-cycle transfer strobe |
| phys_addr | output | 24 | Physical memory address |
| remaining | output | 16 | Current count |
| residue_bytes | output | 18 | Untransferred bytes |
| tc | output | 1 | Terminal-count pulse |

## Verification
The address mapping is tried with an odd page and an offset that has its top bit set. With those values, a wrong shift, a lost page bit or a leaked page bit 0 each gives a different address. Offsets are stepped across 0xFFFF/0x0000 in both directions, which separates wrapping inside the window from carrying into the page. Short counts are run past zero with and without auto-initialise, which separates wrap from reload and checks that the pulse lands on the right cycle. A load taken together with a strobe shows which of the two has priority.

// File: rtl/dma_pg_pkg.sv
package dma_pg_pkg;
  localparam int PAGE_W = 8;
  localparam int OFS_W  = 16;
  localparam int PHYS_W = PAGE_W + OFS_W;

  typedef enum logic {
    XW_BYTE = 1'b0,
    XW_WORD = 1'b1
  } xfer_width_e;
endpackage

// File: rtl/dma_page_reg.sv
module dma_page_reg #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              word_mode,
  input  logic [PAGE_W-1:0] page_in,
  output logic [PAGE_W-1:0] page_q
);
  logic [PAGE_W-1:0] page_d;
  logic              page_en;

  always_comb begin
    page_en = load;
    page_d  = page_in;
    if (word_mode) page_d[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= '0;
    else if (page_en) page_q <= page_d;
  end

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(page_q)); // R4
  AST_PAGE_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (load && word_mode) |=> (page_q[0] == 1'b0)); // R3
endmodule

// File: rtl/dma_ofs_ctr.sv
module dma_ofs_ctr #(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFS_W-1:0] base_in,
  input  logic             step,
  input  logic             dec_mode,
  input  logic             reload,
  output logic [OFS_W-1:0] cur_q
);
  localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

  logic [OFS_W-1:0] base_q, base_d, cur_d;
  logic             base_en, cur_en;

  always_comb begin
    base_en = load;
    base_d  = base_in;
    cur_en  = load | step;
    if (load)        cur_d = base_in;
    else if (reload) cur_d = base_q;
    else if (dec_mode) cur_d = cur_q - ONE;
    else             cur_d = cur_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= base_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (cur_en) cur_q <= cur_d;
  end

  AST_OFS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !reload) |=>
      (cur_q == ($past(dec_mode) ? $past(cur_q) - ONE : $past(cur_q) + ONE))); // R5
  AST_OFS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(cur_q)); // R5
endmodule

// File: rtl/dma_cnt_ctr.sv
module dma_cnt_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] base_in,
  input  logic             xfer,
  input  logic             auto_init,
  output logic [CNT_W-1:0] cnt_q,
  output logic             reload,
  output logic             step,
  output logic             tc_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] base_q, cnt_d;
  logic             cnt_en, term, tc_d;

  always_comb begin
    step   = xfer & ~load;
    term   = step & (cnt_q == '0);
    reload = term & auto_init;
    tc_d   = term;
    cnt_en = load | step;
    if (load)        cnt_d = base_in;
    else if (reload) cnt_d = base_q;
    else             cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    base_q <= '0;
    else if (load) base_q <= base_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tc_q <= 1'b0;
    else        tc_q <= tc_d;
  end

  AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !load && !(auto_init && cnt_q == '0)) |=> (cnt_q == $past(cnt_q) - ONE)); // R6
  AST_TC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !load && cnt_q == '0) |=> tc_q); // R7
  AST_TC_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer && !load && cnt_q == '0) |=> !tc_q); // R7
  AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !load && auto_init && cnt_q == '0) |=> (cnt_q == base_q)); // R8
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(base_in)) && !tc_q); // R10
endmodule

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen
  import dma_pg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [PAGE_W-1:0]   page_in,
  input  logic [OFS_W-1:0]    base_ofs_in,
  input  logic [OFS_W-1:0]    base_cnt_in,
  input  logic                word_mode,
  input  logic                dec_mode,
  input  logic                auto_init,
  input  logic                xfer,
  output logic [PHYS_W-1:0]   phys_addr,
  output logic [OFS_W-1:0]    remaining,
  output logic [OFS_W+1:0]    residue_bytes,
  output logic                tc
);
  logic              rst_meta, rst_n_s;
  logic [PAGE_W-1:0] page_q;
  logic [OFS_W-1:0]  ofs_q;
  logic              reload, step;
  xfer_width_e       width;
  logic [OFS_W:0]    units;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  dma_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk(clk), .rst_n(rst_n_s), .load(load), .word_mode(word_mode),
    .page_in(page_in), .page_q(page_q)
  );

  dma_cnt_ctr #(.CNT_W(OFS_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .load(load), .base_in(base_cnt_in),
    .xfer(xfer), .auto_init(auto_init), .cnt_q(remaining),
    .reload(reload), .step(step), .tc_q(tc)
  );

  dma_ofs_ctr #(.OFS_W(OFS_W)) u_ofs (
    .clk(clk), .rst_n(rst_n_s), .load(load), .base_in(base_ofs_in),
    .step(step), .dec_mode(dec_mode), .reload(reload), .cur_q(ofs_q)
  );

  always_comb begin
    width = word_mode ? XW_WORD : XW_BYTE;
    units = {1'b0, remaining} + {{OFS_W{1'b0}}, 1'b1};
    if (width == XW_WORD) begin
      phys_addr     = {page_q[PAGE_W-1:1], ofs_q, 1'b0};
      residue_bytes = {units, 1'b0};
    end else begin
      phys_addr     = {page_q, ofs_q};
      residue_bytes = {1'b0, units};
    end
  end

  AST_PAGE_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!load && !word_mode && !$past(word_mode)) |=>
      (phys_addr[PHYS_W-1:OFS_W] == $past(phys_addr[PHYS_W-1:OFS_W]))); // R4
endmodule

// File: tb/test_dma_page_addr_gen.sv
module test_dma_page_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [7:0]  page_in = '0;
  logic [15:0] base_ofs_in = '0;
  logic [15:0] base_cnt_in = '0;
  logic        word_mode = 1'b0;
  logic        dec_mode = 1'b0;
  logic        auto_init = 1'b0;
  logic        xfer = 1'b0;
  logic [23:0] phys_addr;
  logic [15:0] remaining;
  logic [17:0] residue_bytes;
  logic        tc;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dma_page_addr_gen i_dma_page_addr_gen (
    .clk(clk), .rst_n(rst_n), .load(load), .page_in(page_in),
    .base_ofs_in(base_ofs_in), .base_cnt_in(base_cnt_in),
    .word_mode(word_mode), .dec_mode(dec_mode), .auto_init(auto_init),
    .xfer(xfer), .phys_addr(phys_addr), .remaining(remaining),
    .residue_bytes(residue_bytes), .tc(tc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] pg, input logic [15:0] ofs, input logic [15:0] cnt);
    page_in = pg; base_ofs_in = ofs; base_cnt_in = cnt; load = 1'b1;
    @(posedge clk); @(negedge clk);
    load = 1'b0;
  endtask

  task automatic do_xfer();
    xfer = 1'b1;
    @(posedge clk); @(negedge clk);
    xfer = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 phys", phys_addr, 24'h0);
    chk("R11 remaining", remaining, 16'h0);
    chk("R11 tc", tc, 1'b0);
  endtask

  task automatic t_byte_map();
    word_mode = 0; dec_mode = 0; auto_init = 0;
    do_load(8'h12, 16'h3456, 16'd2);
    chk("R1 phys", phys_addr, 24'h123456);
    chk("R9 residue byte", residue_bytes, 18'd3);
    do_xfer();
    chk("R5 inc", phys_addr, 24'h123457);
    chk("R6 dec count", remaining, 16'd1);
  endtask

  task automatic t_word_map();
    word_mode = 1;
    do_load(8'h35, 16'h8001, 16'd2);
    chk("R2 phys", phys_addr, 24'h350002);
    chk("R9 residue word", residue_bytes, 18'd6);
    word_mode = 0; #1;
    chk("R3 page bit0 cleared", phys_addr, 24'h348001);
  endtask

  task automatic t_wrap();
    word_mode = 0; dec_mode = 0;
    do_load(8'h7F, 16'hFFFF, 16'd10);
    do_xfer();
    chk("R4 inc wrap", phys_addr, 24'h7F0000);
    dec_mode = 1;
    do_xfer();
    chk("R4 dec wrap", phys_addr, 24'h7FFFFF);
    do_xfer();
    chk("R5 dec", phys_addr, 24'h7FFFFE);
    dec_mode = 0;
  endtask

  task automatic t_tc();
    auto_init = 0;
    do_load(8'h01, 16'h0010, 16'd1);
    do_xfer();
    chk("R7 no tc early", tc, 1'b0);
    chk("R6 count", remaining, 16'd0);
    do_xfer();
    chk("R7 tc pulse", tc, 1'b1);
    chk("R7 count wrap", remaining, 16'hFFFF);
    chk("R7 addr stepped", phys_addr, 24'h010012);
    @(posedge clk); @(negedge clk);
    chk("R7 tc drops", tc, 1'b0);
  endtask

  task automatic t_auto();
    auto_init = 1;
    do_load(8'h05, 16'h1000, 16'd1);
    do_xfer();
    do_xfer();
    chk("R8 tc", tc, 1'b1);
    chk("R8 addr reload", phys_addr, 24'h051000);
    chk("R8 count reload", remaining, 16'd1);
    auto_init = 0;
  endtask

  task automatic t_priority();
    page_in = 8'hA0; base_ofs_in = 16'h0200; base_cnt_in = 16'd0;
    load = 1; xfer = 1;
    @(posedge clk); @(negedge clk);
    load = 0; xfer = 0;
    chk("R10 addr", phys_addr, 24'hA00200);
    chk("R10 count", remaining, 16'd0);
    chk("R10 tc", tc, 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_chk++; n_bad++;
          $display("FAIL watchdog actual=hung expected=finish");
          $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
          $finish;
        end
      end
    join_none
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_byte_map();
    t_word_map();
    t_wrap();
    t_tc();
    t_auto();
    t_priority();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule